// File: doc/BRIEF.md
# Programmable Down-Count Event Timer

One timer channel with a small register window. Software arms it by writing a single control word. That word holds an enable flag, a mode flag (one-shot or periodic) and a 29-bit start value. While the channel is armed, every pulse on a shared tick input moves the count one step toward zero. When a tick arrives with the count already at zero, the channel expires and a level interrupt is raised. A start value of N therefore produces an interrupt after N+1 ticks.

In periodic mode, the count reloads the stored start value on expiry and the channel keeps running. In one-shot mode, the channel disarms itself and the count rests at zero. Writing an all-zero control word halts the channel at once. The interrupt is sticky: it stays high until software writes a one to the acknowledge bit of the status word. The channel occupies an 8-byte window, so identical channels can be placed at a fixed stride by the surrounding fabric.

Top module: `tmr_channel`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0 and `irq` is low.
- R2: A write to byte offset 0x0 loads the control word. Bit 31 is the enable flag, bit 30 is the periodic flag and bits 28:0 are the start value (maximum 0x1FFFFFFF). The running count is set to the start value. Reading offset 0x0 returns the two flags in bits 31 and 30, 0 in bit 29 and the live count in bits 28:0.
- R3: While enabled, each tick on a nonzero count decrements it, and a tick on a zero count is an expiry, so a start value of N expires on tick N+1. Ticks have no effect while the channel is disabled.
- R4: On a one-shot expiry the enable flag clears and the count holds at zero. Later ticks raise no further interrupt.
- R5: On a periodic expiry the count reloads the start value and the enable flag stays set, giving one expiry every N+1 ticks with no further writes.
- R6: Writing 0x00000000 to offset 0x0 stops the channel immediately: the count becomes zero and no further expiry occurs.
- R7: `irq` rises in the cycle after an expiry and stays high until it is acknowledged.
- R8: A write to byte offset 0x4 with bit 30 set clears `irq`. A write there with bit 30 clear changes nothing. Reading offset 0x4 returns `irq` in bit 30 and 0 elsewhere.
- R9: If an acknowledge and an expiry fall in the same cycle, `irq` stays high.
- R10: A control write restarts the count from the new start value, including while the channel is running. If it coincides with a tick, the write wins and no expiry occurs in that cycle.
- R11: Writes to any byte offset other than 0x0 and 0x4 are ignored, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared count pulse, one clock wide per step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Byte offset of the write within the channel window |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Sticky interrupt level |

## Verification
The assertions assume that `tick` and `wr_en` are free of X after reset. They also assume that a control write only becomes visible in the cycle after its strobe. Apart from that, they accept any mix of ticks and writes, including a tick coinciding with a control write or with an acknowledge. The bench drives every input on the falling clock edge, so each strobe is seen at exactly one rising edge. It reads the registers half a cycle later, so every count and flag is observed after the edge that updated it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2
  } tmr_reg_e;
endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 29,
  parameter int OFS_W    = 3,
  parameter int CTRL_OFS = 0,
  parameter int STAT_OFS = 4
) (
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFS_W-1:0]  rd_addr,
  input  logic              en,
  input  logic              per,
  input  logic [CNT_W-1:0]  count,
  input  logic              irq,
  output logic              ctrl_wr,
  output logic              clr_req,
  output logic              wr_en_bit,
  output logic              wr_per_bit,
  output logic [CNT_W-1:0]  wr_load,
  output logic [DATA_W-1:0] rd_data
);
  localparam int EN_BIT  = DATA_W - 1;
  localparam int PER_BIT = DATA_W - 2;
  localparam int ACK_BIT = DATA_W - 2;
  localparam int GAP_W   = DATA_W - 2 - CNT_W;

  function automatic tmr_reg_e decode(input logic [OFS_W-1:0] ofs);
    if (ofs == OFS_W'(CTRL_OFS))      return REG_CTRL;
    else if (ofs == OFS_W'(STAT_OFS)) return REG_STAT;
    else                              return REG_NONE;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(input logic e, input logic p,
                                                  input logic [CNT_W-1:0] c);
    return {e, p, {GAP_W{1'b0}}, c};
  endfunction

  function automatic logic [DATA_W-1:0] pack_stat(input logic i);
    logic [DATA_W-1:0] w;
    w = '0;
    w[ACK_BIT] = i;
    return w;
  endfunction

  tmr_reg_e wsel, rsel;

  always_comb begin
    wsel       = decode(wr_addr);
    rsel       = decode(rd_addr);
    ctrl_wr    = wr_en && (wsel == REG_CTRL);
    clr_req    = wr_en && (wsel == REG_STAT) && wr_data[ACK_BIT];
    wr_en_bit  = wr_data[EN_BIT];
    wr_per_bit = wr_data[PER_BIT];
    wr_load    = wr_data[CNT_W-1:0];
    case (rsel)
      REG_CTRL: rd_data = pack_ctrl(en, per, count);
      REG_STAT: rd_data = pack_stat(irq);
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctrl_wr,
  input  logic             wr_en_bit,
  input  logic             wr_per_bit,
  input  logic [CNT_W-1:0] wr_load,
  output logic             en,
  output logic             per,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] load,
  output logic             expire
);
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic [CNT_W-1:0] l,
                                            input logic p);
    if (c != '0) return c - 1'b1;
    else if (p)  return l;
    else         return '0;
  endfunction

  logic step_en;

  always_comb begin
    step_en = en && tick && !ctrl_wr;
    expire  = step_en && (count == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      per   <= 1'b0;
      count <= '0;
      load  <= '0;
    end else if (ctrl_wr) begin
      en    <= wr_en_bit;
      per   <= wr_per_bit;
      count <= wr_load;
      load  <= wr_load;
    end else if (step_en) begin
      count <= step(count, load, per);
      if (expire && !per) en <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_req,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)       irq <= 1'b0;
    else if (expire)  irq <= 1'b1;
    else if (clr_req) irq <= 1'b0;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 29,
  parameter int OFS_W    = 3,
  parameter int CTRL_OFS = 0,
  parameter int STAT_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFS_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic             ctrl_wr, clr_req, wr_en_bit, wr_per_bit;
  logic [CNT_W-1:0] wr_load;
  logic             en_q, per_q, expire;
  logic [CNT_W-1:0] count_q, load_q;

  tmr_regif #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .OFS_W(OFS_W),
    .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
  ) u_regif (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .en(en_q), .per(per_q), .count(count_q), .irq(irq),
    .ctrl_wr(ctrl_wr), .clr_req(clr_req), .wr_en_bit(wr_en_bit),
    .wr_per_bit(wr_per_bit), .wr_load(wr_load), .rd_data(rd_data)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_wr(ctrl_wr),
    .wr_en_bit(wr_en_bit), .wr_per_bit(wr_per_bit), .wr_load(wr_load),
    .en(en_q), .per(per_q), .count(count_q), .load(load_q), .expire(expire)
  );

  tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr_req(clr_req), .irq(irq)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ctrl_wr,
  input logic             clr_req,
  input logic             wr_en_bit,
  input logic [CNT_W-1:0] wr_load,
  input logic             en_q,
  input logic             per_q,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] load_q,
  input logic             expire,
  input logic             irq
);
  // R2, R10: a control write sets the count to the written start value
  a_r10_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (count_q == $past(wr_load)) && (en_q == $past(wr_en_bit)));

  // R3: an armed tick on a nonzero count takes one step down
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick && !ctrl_wr && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));

  // R3, R6: with no write, a disarmed channel holds its count
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ctrl_wr) |=> $stable(count_q) && !en_q);

  // R4: one-shot expiry disarms and rests at zero
  a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !per_q) |=> (!en_q && count_q == '0));

  // R5: periodic expiry reloads and stays armed
  a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && per_q) |=> (en_q && count_q == $past(load_q)));

  // R7, R9: an expiry always leaves irq high
  a_r7_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq);

  // R7: irq never rises without an expiry
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !expire) |=> !irq);

  // R8: an acknowledge with no coincident expiry drops irq
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !expire) |=> !irq);
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_wr(ctrl_wr), .clr_req(clr_req),
  .wr_en_bit(wr_en_bit), .wr_load(wr_load), .en_q(en_q), .per_q(per_q),
  .count_q(count_q), .load_q(load_q), .expire(expire), .irq(irq)
);

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_channel i_tmr_channel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [31:0] ctrl_word(input bit e, input bit p, input int unsigned n);
    return {e, p, 1'b0, 29'(n)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cycle(input bit we, input logic [2:0] a, input logic [31:0] d, input bit tk);
    wr_en = we; wr_addr = a; wr_data = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cycle(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 3'd0, 32'd0, 1'b1);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic check_ctrl(input string req, input logic [31:0] exp);
    logic [31:0] v;
    rd(3'd0, v);
    check(req, v, exp);
  endtask

  task automatic check_irq(input string req, input bit exp);
    logic [31:0] v;
    rd(3'd4, v);
    check(req, {31'd0, irq}, {31'd0, exp});
    check(req, v, exp ? 32'h4000_0000 : 32'h0);
  endtask

  task automatic t_reset;
    check_ctrl("R1 ctrl", 32'h0);
    check_irq("R1 irq", 1'b0);
  endtask

  task automatic t_load_readback;
    wr(3'd0, 32'hFFFF_FFFF);
    check_ctrl("R2 max value, bit29 reads 0", 32'hDFFF_FFFF);
    wr(3'd0, ctrl_word(0, 1, 12345));
    check_ctrl("R2 flags and value", ctrl_word(0, 1, 12345));
    wr(3'd0, 32'h0);
  endtask

  task automatic t_disabled_ticks;
    wr(3'd0, ctrl_word(0, 0, 5));
    ticks(4);
    check_ctrl("R3 disabled hold", ctrl_word(0, 0, 5));
    check_irq("R3 disabled no irq", 1'b0);
  endtask

  task automatic t_oneshot;
    wr(3'd0, ctrl_word(1, 0, 3));
    ticks(3);
    check_ctrl("R3 count after N ticks", ctrl_word(1, 0, 0));
    check_irq("R3 no expiry before N+1", 1'b0);
    ticks(1);
    check_irq("R7 expiry on tick N+1", 1'b1);
    check_ctrl("R4 one-shot disarmed at zero", 32'h0);
    ticks(2);
    check_irq("R7 irq sticky", 1'b1);
    wr(3'd4, 32'h4000_0000);
    ticks(3);
    check_irq("R4 no re-expiry", 1'b0);
  endtask

  task automatic t_periodic;
    wr(3'd0, ctrl_word(1, 1, 2));
    ticks(3);
    check_irq("R5 first period", 1'b1);
    check_ctrl("R5 reloaded", ctrl_word(1, 1, 2));
    wr(3'd4, 32'h4000_0000);
    check_irq("R8 ack clears", 1'b0);
    ticks(2);
    check_irq("R5 mid period", 1'b0);
    ticks(1);
    check_irq("R5 second period", 1'b1);
    ticks(1);
    check_ctrl("R5 running", ctrl_word(1, 1, 1));
    wr(3'd0, 32'h0);
    check_ctrl("R6 stop", 32'h0);
    wr(3'd4, 32'h4000_0000);
    ticks(5);
    check_irq("R6 no expiry after stop", 1'b0);
  endtask

  task automatic t_ack_bits;
    wr(3'd0, ctrl_word(1, 0, 0));
    ticks(1);
    check_irq("R8 set for ack test", 1'b1);
    wr(3'd4, 32'hBFFF_FFFF);
    check_irq("R8 bit30 clear ignored", 1'b1);
    wr(3'd4, 32'h4000_0000);
    check_irq("R8 bit30 set clears", 1'b0);
  endtask

  task automatic t_ack_vs_expire;
    wr(3'd0, ctrl_word(1, 1, 0));
    ticks(1);
    check_irq("R9 setup", 1'b1);
    cycle(1'b1, 3'd4, 32'h4000_0000, 1'b1);
    check_irq("R9 expiry wins", 1'b1);
    wr(3'd4, 32'h4000_0000);
    check_irq("R9 later ack", 1'b0);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_write_vs_tick;
    wr(3'd0, ctrl_word(1, 0, 9));
    ticks(2);
    check_ctrl("R10 running", ctrl_word(1, 0, 7));
    wr(3'd0, ctrl_word(1, 0, 2));
    check_ctrl("R10 restart", ctrl_word(1, 0, 2));
    wr(3'd0, ctrl_word(1, 0, 0));
    cycle(1'b1, 3'd0, ctrl_word(1, 0, 4), 1'b1);
    check_irq("R10 write beats tick", 1'b0);
    check_ctrl("R10 new value", ctrl_word(1, 0, 4));
    ticks(4);
    check_irq("R10 no early expiry", 1'b0);
    ticks(1);
    check_irq("R10 expiry after N+1", 1'b1);
  endtask

  task automatic t_other_offsets;
    logic [31:0] v;
    wr(3'd2, ctrl_word(1, 1, 7));
    wr(3'd6, 32'h4000_0000);
    wr(3'd1, 32'hFFFF_FFFF);
    check_ctrl("R11 ctrl untouched", 32'h0);
    check_irq("R11 irq untouched", 1'b1);
    rd(3'd6, v);
    check("R11 unmapped read", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_readback();
    t_disabled_ticks();
    t_oneshot();
    t_periodic();
    t_ack_bits();
    t_ack_vs_expire();
    t_write_vs_tick();
    t_other_offsets();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule